// File: doc/BRIEF.md
# Shift-Register Noise Source

This block generates the one-bit noise voice of a programmable sound generator. A 15-bit linear-feedback shift register is advanced by a step pulse. The register's lowest bit is the noise output. The step comes from one of two places. The first is a counter of prescaler ticks with three selectable lengths. The second is the rising edge of a neighbouring square-wave tone voice, so that voice's pitch sets the noise pitch. A type bit picks the feedback. White noise gives a long pseudo-random sequence. Periodic noise gives a short pulse train that repeats every 15 steps.

The surrounding register file holds the 3-bit control value and drives it steadily. It also raises a write strobe while the value is being written. When that strobe is released, the block reloads its seed and clears its tick counter, so every write starts the sequence from a known point. The inputs are plain level and pulse controls, and the output is a plain level. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure. Attenuation and mixing belong to other blocks.

Top module: `noise_channel`

## Requirements
- R1: After synchronous reset the register holds the seed 15'h4000, the tick counter is zero, and `noise_out` is 0.
- R2: With `noise_ctrl[1:0]` = 2'b00, the register advances once every BASE_TICKS cycles in which `prescale_tick` is high.
- R3: With `noise_ctrl[1:0]` = 2'b01, the register advances once every 2*BASE_TICKS prescaler ticks.
- R4: With `noise_ctrl[1:0]` = 2'b10, the register advances once every 4*BASE_TICKS prescaler ticks.
- R5: With `noise_ctrl[1:0]` = 2'b11, the register advances once in the cycle after `tone2_in` goes from 0 to 1. Prescaler ticks, a held high level and falling edges do not advance it.
- R6: With `noise_ctrl[2]` = 1 (white), each step shifts the register right by one. The new bit 14 is bit 0 XOR bit 1. `noise_out` is bit 0.
- R7: With `noise_ctrl[2]` = 0 (periodic), the new bit 14 is bit 0 alone. Starting from the seed, `noise_out` is 1 after step 14 and after every 15th step from then on, and 0 after all other steps.
- R8: A 1-to-0 transition of `ctrl_wr` reloads the seed and clears the tick counter on the next clock edge. While `ctrl_wr` stays high, nothing is reloaded.
- R9: In the three divider rates, `tone2_in` has no effect on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| prescale_tick | input | 1 | One-cycle pulse from the master clock prescaler |
| tone2_in | input | 1 | Square-wave output of the neighbouring tone voice |
| noise_ctrl | input | 3 | Bit 2: white (1) or periodic (0). Bits 1:0: rate select |
| ctrl_wr | input | 1 | Level write strobe for the control value; release starts a restart |
| noise_out | output | 1 | Noise bit (register bit 0) |

## Verification
The bench uses the default 15-bit width and the 15'h4000 seed. It sets BASE_TICKS to 4, so the three divider rates step every 4, 8 and 16 ticks. At those lengths the bench can run dozens of white and periodic steps at every rate. It can also count the exact tick where the first periodic pulse appears (step 14), which shows that both the seed and the counter are cleared. The short counter also makes it cheap to check that a release partway through a count restarts from zero. It also lets a long train of ignored ticks run before the tone-driven tests.

// File: rtl/noise_pkg.sv
package noise_pkg;
  typedef enum logic [1:0] {
    RATE_X1   = 2'b00,
    RATE_X2   = 2'b01,
    RATE_X4   = 2'b10,
    RATE_TONE = 2'b11
  } rate_e;

  typedef struct packed {
    logic  white;
    rate_e rate;
  } noise_ctrl_t;
endpackage

// File: rtl/noise_restart.sv
module noise_restart (
  input  logic clk,
  input  logic rst,
  input  logic wr_i,
  output logic restart_o
);
  logic wr_q;

  always_ff @(posedge clk) begin
    if (rst) wr_q <= 1'b0;
    else     wr_q <= wr_i;
  end

  // a restart is issued on release of the strobe
  assign restart_o = wr_q & ~wr_i;

  // R8: restart only while the strobe is low
  a_r8_on_release: assert property (@(posedge clk) disable iff (rst)
    restart_o |-> !wr_i);
  // R8: restart lasts one cycle
  a_r8_single: assert property (@(posedge clk) disable iff (rst)
    restart_o |=> !restart_o);
endmodule

// File: rtl/noise_rate_gen.sv
module noise_rate_gen
  import noise_pkg::*;
#(
  parameter int BASE_TICKS = 32
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  tick_i,
  input  logic  tone_i,
  input  rate_e rate_i,
  input  logic  clear_i,
  output logic  step_o
);
  localparam int CW = $clog2(BASE_TICKS * 4);
  localparam logic [CW:0] LIM_X1 = (CW+1)'(BASE_TICKS);
  localparam logic [CW:0] LIM_X2 = (CW+1)'(BASE_TICKS * 2);
  localparam logic [CW:0] LIM_X4 = (CW+1)'(BASE_TICKS * 4);
  localparam logic [CW:0] ONE    = (CW+1)'(1);

  logic [CW-1:0] cnt;
  logic [CW:0]   lim;
  logic          tone_q;
  logic          div_hit;
  logic          tone_rise;

  always_comb begin
    case (rate_i)
      RATE_X1: lim = LIM_X1;
      RATE_X2: lim = LIM_X2;
      default: lim = LIM_X4;
    endcase
  end

  assign div_hit   = tick_i && ({1'b0, cnt} >= (lim - ONE));
  assign tone_rise = tone_i & ~tone_q;
  assign step_o    = (rate_i == RATE_TONE) ? tone_rise : div_hit;

  always_ff @(posedge clk) begin
    if (rst) tone_q <= 1'b0;
    else     tone_q <= tone_i;
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i || rate_i == RATE_TONE) cnt <= '0;
    else if (tick_i) begin
      if (div_hit) cnt <= '0;
      else         cnt <= cnt + 1'b1;
    end
  end

  // R2: no divider step without a prescaler tick
  a_r2_tick_gate: assert property (@(posedge clk) disable iff (rst)
    (rate_i != RATE_TONE && !tick_i) |-> !step_o);
  // R5: tone-driven step only while the tone is high
  a_r5_tone_high: assert property (@(posedge clk) disable iff (rst)
    (rate_i == RATE_TONE && step_o) |-> tone_i);
  // R5: no two tone steps back to back
  a_r5_no_repeat: assert property (@(posedge clk) disable iff (rst)
    (rate_i == RATE_TONE && step_o) |=> (rate_i != RATE_TONE || !step_o));
endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr #(
  parameter int             W    = 15,
  parameter logic [W-1:0]   SEED = 15'h4000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  input  logic step_i,
  input  logic white_i,
  output logic bit_o
);
  logic [W-1:0] state;
  logic         fb;

  assign fb    = white_i ? (state[0] ^ state[1]) : state[0];
  assign bit_o = state[0];

  always_ff @(posedge clk) begin
    if (rst || restart_i) state <= SEED;
    else if (step_i)      state <= {fb, state[W-1:1]};
  end

  // R8: restart loads the seed
  a_r8_seed: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (state == SEED));
  // R6: register holds between steps
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!restart_i && !step_i) |=> $stable(state));
  // R6: never falls into the all-zero lock-up state
  a_r6_live: assert property (@(posedge clk) disable iff (rst)
    state != '0);
endmodule

// File: rtl/noise_channel.sv
module noise_channel
  import noise_pkg::*;
#(
  parameter int                 LFSR_W     = 15,
  parameter logic [LFSR_W-1:0]  SEED       = 15'h4000,
  parameter int                 BASE_TICKS = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       prescale_tick,
  input  logic       tone2_in,
  input  logic [2:0] noise_ctrl,
  input  logic       ctrl_wr,
  output logic       noise_out
);
  noise_ctrl_t ctrl;
  logic        restart;
  logic        step;

  assign ctrl = noise_ctrl_t'(noise_ctrl);

  noise_restart u_restart (
    .clk       (clk),
    .rst       (rst),
    .wr_i      (ctrl_wr),
    .restart_o (restart)
  );

  noise_rate_gen #(.BASE_TICKS(BASE_TICKS)) u_rate (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (prescale_tick),
    .tone_i  (tone2_in),
    .rate_i  (ctrl.rate),
    .clear_i (restart),
    .step_o  (step)
  );

  noise_lfsr #(.W(LFSR_W), .SEED(SEED)) u_lfsr (
    .clk       (clk),
    .rst       (rst),
    .restart_i (restart),
    .step_i    (step),
    .white_i   (ctrl.white),
    .bit_o     (noise_out)
  );
endmodule

// File: tb/noise_channel_tb.sv
module noise_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 4;
  localparam logic [14:0] SEED = 15'h4000;

  // {ctrl[2:0], steps}: R2/R3/R4 rates with R6 white or R7 periodic
  localparam logic [10:0] VECS [5] = '{
    {3'b000, 8'd20},   // R2 R7
    {3'b100, 8'd30},   // R2 R6
    {3'b101, 8'd12},   // R3 R6
    {3'b110, 8'd6},    // R4 R6
    {3'b010, 8'd16}    // R4 R7
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       prescale_tick = 1'b0;
  logic       tone2_in = 1'b0;
  logic [2:0] noise_ctrl = 3'b000;
  logic       ctrl_wr = 1'b0;
  logic       noise_out;

  int nchk = 0;
  int nfail = 0;
  logic [14:0] m;

  always #(CLK_PERIOD/2) clk = ~clk;

  noise_channel #(.BASE_TICKS(BASE)) u_dut (
    .clk(clk), .rst(rst), .prescale_tick(prescale_tick), .tone2_in(tone2_in),
    .noise_ctrl(noise_ctrl), .ctrl_wr(ctrl_wr), .noise_out(noise_out)
  );

  function automatic logic [14:0] nxt(logic [14:0] s, logic white);
    return {white ? (s[0] ^ s[1]) : s[0], s[14:1]};
  endfunction

  task automatic chk(string req, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 prescale_tick = 1'b1;
      @(posedge clk); #1 prescale_tick = 1'b0;
    end
  endtask

  task automatic write_ctrl(logic [2:0] c);
    @(posedge clk); #1 noise_ctrl = c; ctrl_wr = 1'b1;
    @(posedge clk); #1 ctrl_wr = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic tone_edge(logic white);
    @(posedge clk); #1 tone2_in = 1'b1;
    @(posedge clk); #1;
    m = nxt(m, white);
    chk("R5 rise", noise_out, m[0]);
    @(posedge clk); #1;
    chk("R5 high level", noise_out, m[0]);
    tone2_in = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk("R5 fall", noise_out, m[0]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    string rq;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: reset state
    chk("R1 reset output", noise_out, 1'b0);
    do_tick(14*BASE - 1);
    chk("R1 seed/count", noise_out, 1'b0);
    do_tick(1);
    chk("R1 R7 first pulse", noise_out, 1'b1);

    // table walk
    foreach (VECS[v]) begin
      logic [2:0] c;
      int steps;
      int lim;
      c = VECS[v][10:8];
      steps = int'(VECS[v][7:0]);
      lim = BASE << c[1:0];
      case (c[1:0])
        2'b00:   rq = c[2] ? "R2 R6" : "R2 R7";
        2'b01:   rq = c[2] ? "R3 R6" : "R3 R7";
        default: rq = c[2] ? "R4 R6" : "R4 R7";
      endcase
      write_ctrl(c);
      m = SEED;
      for (int s = 0; s < steps; s++) begin
        do_tick(lim - 1);
        chk(rq, noise_out, m[0]);
        m = nxt(m, c[2]);
        do_tick(1);
        chk(rq, noise_out, m[0]);
      end
    end

    // R8: held strobe does not restart; release clears seed and count
    write_ctrl(3'b000);
    do_tick(14*BASE);
    chk("R8 pre", noise_out, 1'b1);
    do_tick(BASE - 1);
    @(posedge clk); #1 ctrl_wr = 1'b1;
    repeat (5) @(posedge clk);
    #1 chk("R8 held high", noise_out, 1'b1);
    ctrl_wr = 1'b0;
    @(posedge clk); #1;
    chk("R8 release reload", noise_out, 1'b0);
    do_tick(14*BASE - 1);
    chk("R8 count cleared", noise_out, 1'b0);
    do_tick(1);
    chk("R8 count cleared", noise_out, 1'b1);

    // R5: tone-driven stepping, ticks ignored
    write_ctrl(3'b111);
    m = SEED;
    do_tick(12*BASE);
    chk("R5 ticks ignored", noise_out, m[0]);
    for (int k = 0; k < 20; k++) tone_edge(1'b1);
    write_ctrl(3'b011);
    m = SEED;
    for (int k = 0; k < 16; k++) tone_edge(1'b0);

    // R9: tone input ignored in divider rate
    write_ctrl(3'b000);
    for (int k = 0; k < 30; k++) begin
      @(posedge clk); #1 tone2_in = ~tone2_in;
    end
    #1 tone2_in = 1'b0;
    chk("R9 no step", noise_out, 1'b0);
    do_tick(14*BASE - 1);
    chk("R9 count intact", noise_out, 1'b0);
    do_tick(1);
    chk("R9 count intact", noise_out, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule